// File: doc/BRIEF.md
# Serial DDR Sample Transmitter with Frame Marker

This block is the transmit side of a single-lane converter output. Once per frame a strobe marks one cycle in which a 12-bit sample is taken. After a fixed latency of six and a half frames, the sample leaves the block one bit per internal cycle, starting with the least significant bit, on a single data line.

Next to the data the block drives three signals. The first is a bit clock at six times the frame rate, so that one data bit sits on each of its edges. The second is a frame marker whose rising edge lines up with bit 0 of every frame. The third is a valid flag that marks the frames that carry a sample.

Everything runs in one fast clock domain at twelve times the frame rate, which is twice the bit-clock rate. The bit clock is therefore produced as a registered, data-like output that changes level on every internal cycle. A system uses the block by pulsing the strobe every twelve cycles with a fresh sample. A receiver model can then frame the stream by watching the marker.

Top module: `adc_ser_tx`

## Requirements
- R1: While reset is asserted (rst_n low), ser_data, bit_clk, frame_out and out_valid are all 0.
- R2: If frame_stb is high in internal cycle k, bit 0 of that cycle's sample_in appears on ser_data in cycle k+78. That is 6.5 frames of 12 cycles.
- R3: Within an output frame, cycle i (0 to 11) carries bit i of the sample on ser_data, with bit 0 first and bit 11 last.
- R4: Before the first output frame, bit_clk stays 0. From the first frame on, bit_clk is 1 in even cycles and 0 in odd cycles of the frame phase, so it toggles every internal cycle and runs at 1/6 of the frame rate's bit period.
- R5: frame_out is 1 in phase cycles 0 to 5 and 0 in phase cycles 6 to 11, and its rising edge coincides with bit 0. Before the first output frame it is 0.
- R6: out_valid is 1 in exactly the 12 cycles of a frame that carries a sample. It stays 0 after reset until the first sample has passed the full latency.
- R7: sample_in is ignored in every cycle where frame_stb is 0.
- R8: Once a frame ends with no new sample following it, ser_data is 0 and out_valid is 0. The bit clock and the frame marker keep their phase and keep running.
- R9: Strobes spaced exactly 12 cycles apart give back-to-back output frames with no gap. A strobe that arrives after an irregular gap restarts the frame phase at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at twelve times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle sampling strobe, once per frame |
| sample_in | input | 12 | Sample word, taken when frame_stb is high |
| ser_data | output | 1 | Serial data, least significant bit first |
| bit_clk | output | 1 | Bit clock; each of its edges carries one bit |
| frame_out | output | 1 | Frame marker, rises with bit 0 |
| out_valid | output | 1 | High while the current frame carries a sample |

## Verification
The first test is a long burst of strobes twelve cycles apart with random samples, which checks gapless framing and the bit order. The burst opens with the words all ones, all zeros, 0xA5A, 0x001 and 0x800. These single out a reversed bit order, a stuck line and an off-by-one bit slot. Between strobes, sample_in carries random noise, so any capture outside the strobe cycle shows up as wrong data. A second burst after a gap of 29 cycles and two isolated strobes test the phase restart and the idle state between frames, where the marker must keep running while data and valid stay low.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

  // Output latency in internal cycles for a latency given in half frames.
  function automatic int lat_cycles(input int half_frames, input int bits_per_frame);
    return (half_frames * bits_per_frame) / 2;
  endfunction

  // Frame marker level for a phase position inside the frame.
  function automatic logic marker_level(input int phase, input int bits_per_frame);
    return (phase < (bits_per_frame / 2));
  endfunction

  // Bit clock level for a phase position: high on even bit slots.
  function automatic logic bitclk_level(input int phase);
    return ((phase % 2) == 0);
  endfunction

endpackage

// File: rtl/adc_ser_capture.sv
module adc_ser_capture #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] din,
  output logic         q_vld,
  output logic [W-1:0] q_dat
);

  // The sampling edge: the word is held only when the strobe is present.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= 1'b0;
      q_dat <= '0;
    end else begin
      q_vld <= stb;
      if (stb) q_dat <= din;
    end
  end

endmodule

// File: rtl/adc_ser_delay.sv
module adc_ser_delay #(
  parameter int W     = 12,
  parameter int DEPTH = 76
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign out_vld = in_vld;
      assign out_dat = in_dat;
    end else begin : g_line
      logic         vld_q [DEPTH];
      logic [W-1:0] dat_q [DEPTH];

      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        logic         vld_d;
        logic [W-1:0] dat_d;
        if (s == 0) begin : g_head
          assign vld_d = in_vld;
          assign dat_d = in_dat;
        end else begin : g_body
          assign vld_d = vld_q[s-1];
          assign dat_d = dat_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            vld_q[s] <= 1'b0;
            dat_q[s] <= '0;
          end else begin
            vld_q[s] <= vld_d;
            dat_q[s] <= dat_d;
          end
        end
      end

      assign out_vld = vld_q[DEPTH-1];
      assign out_dat = dat_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/adc_ser_shifter.sv
module adc_ser_shifter
  import adc_ser_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         ser_data,
  output logic         bit_clk,
  output logic         frame_out,
  output logic         out_valid
);

  localparam int IDX_W = (W > 2) ? $clog2(W) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(W - 1);

  logic [W-1:0]     sh_q;
  logic [IDX_W-1:0] idx_q;
  logic             run_q;
  logic             vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
      run_q <= 1'b0;
      vld_q <= 1'b0;
    end else if (load) begin
      sh_q  <= din;
      idx_q <= '0;
      run_q <= 1'b1;
      vld_q <= 1'b1;
    end else if (run_q) begin
      sh_q <= sh_q >> 1;
      if (idx_q == LAST) begin
        idx_q <= '0;
        vld_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign ser_data  = sh_q[0];
  assign bit_clk   = run_q & bitclk_level(int'(idx_q));
  assign frame_out = run_q & marker_level(int'(idx_q), W);
  assign out_valid = vld_q;

endmodule

// File: rtl/adc_ser_tx.sv
module adc_ser_tx
  import adc_ser_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int LAT_HALVES = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_stb,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic                ser_data,
  output logic                bit_clk,
  output logic                frame_out,
  output logic                out_valid
);

  localparam int LAT_CYC   = lat_cycles(LAT_HALVES, SAMPLE_W);
  localparam int DLY_DEPTH = LAT_CYC - 2;

  // Named internal events for the checker.
  logic                cap_vld;
  logic [SAMPLE_W-1:0] cap_dat;
  logic                load_pulse;
  logic [SAMPLE_W-1:0] load_dat;

  adc_ser_capture #(.W(SAMPLE_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (frame_stb),
    .din   (sample_in),
    .q_vld (cap_vld),
    .q_dat (cap_dat)
  );

  adc_ser_delay #(.W(SAMPLE_W), .DEPTH(DLY_DEPTH)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (cap_vld),
    .in_dat  (cap_dat),
    .out_vld (load_pulse),
    .out_dat (load_dat)
  );

  adc_ser_shifter #(.W(SAMPLE_W)) u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_pulse),
    .din       (load_dat),
    .ser_data  (ser_data),
    .bit_clk   (bit_clk),
    .frame_out (frame_out),
    .out_valid (out_valid)
  );

endmodule

// File: rtl/adc_ser_tx_chk.sv
module adc_ser_tx_chk #(
  parameter int LAT_CYC = 78
) (
  input logic clk,
  input logic rst_n,
  input logic frame_stb,
  input logic load_pulse,
  input logic ser_data,
  input logic bit_clk,
  input logic frame_out,
  input logic out_valid
);

  logic [31:0] cyc_q;
  logic [31:0] first_stb_q;
  logic        stb_seen_q;
  logic        out_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q       <= '0;
      first_stb_q <= '0;
      stb_seen_q  <= 1'b0;
      out_seen_q  <= 1'b0;
    end else begin
      cyc_q <= cyc_q + 1;
      if (frame_stb && !stb_seen_q) begin
        first_stb_q <= cyc_q;
        stb_seen_q  <= 1'b1;
      end
      if (out_valid) out_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!ser_data && !bit_clk && !frame_out && !out_valid)
        else $error("outputs active during reset");
    end
  end

  assert_first_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_seen_q) |-> (stb_seen_q && (cyc_q - first_stb_q == 32'(LAT_CYC))));

  assert_bitclk_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> (bit_clk != $past(bit_clk)));

  assert_marker_on_d0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_out) |-> bit_clk);

  assert_valid_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_seen_q |-> !out_valid);

  assert_valid_opens_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (frame_out && bit_clk));

  assert_idle_line_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !ser_data);

  assert_load_starts_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> (out_valid && bit_clk && frame_out));

endmodule

bind adc_ser_tx adc_ser_tx_chk #(.LAT_CYC(LAT_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_stb  (frame_stb),
  .load_pulse (load_pulse),
  .ser_data   (ser_data),
  .bit_clk    (bit_clk),
  .frame_out  (frame_out),
  .out_valid  (out_valid)
);

// File: tb/adc_ser_tx_tb.sv
module adc_ser_tx_tb;

  localparam int W    = 12;
  localparam int LAT  = 78;
  localparam int NCYC = 700;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_stb = 1'b0;
  logic [W-1:0] sample_in = '0;
  logic         ser_data, bit_clk, frame_out, out_valid;

  int checks = 0;
  int fails  = 0;

  logic         strb [NCYC];
  logic [W-1:0] sdat [NCYC];

  always #2.5 clk = ~clk;

  adc_ser_tx u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .sample_in (sample_in),
    .ser_data  (ser_data),
    .bit_clk   (bit_clk),
    .frame_out (frame_out),
    .out_valid (out_valid)
  );

  function automatic logic exp_bitclk(input int t);
    return ((t % 12) % 2) == 0;
  endfunction

  function automatic logic exp_marker(input int t);
    return (t % 12) < 6;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input int c);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", tag, c, act, exp);
    end
  endtask

  task automatic put(input int c, input logic [W-1:0] d);
    strb[c] = 1'b1;
    sdat[c] = d;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seed_r;
    int last_load;
    int prev_load;
    logic [W-1:0] ldat;
    seed_r = $urandom(32'd20240611);

    for (int c = 0; c < NCYC; c++) begin
      strb[c] = 1'b0;
      sdat[c] = W'($urandom);
    end
    // Burst A: gapless, corner words first.
    for (int i = 0; i < 20; i++) put(3 + 12 * i, W'($urandom));
    put(3,  12'hFFF);
    put(15, 12'h000);
    put(27, 12'hA5A);
    put(39, 12'h001);
    put(51, 12'h800);
    // Burst B after an irregular gap.
    for (int i = 0; i < 12; i++) put(260 + 12 * i, W'($urandom));
    // Isolated strobes and a short final burst.
    put(450, 12'h5A5);
    put(500, 12'hFFF);
    for (int i = 0; i < 3; i++) put(530 + 12 * i, W'($urandom));

    // R1: reset state.
    repeat (4) begin
      @(negedge clk);
      check("R1 ser_data", ser_data, 1'b0, -1);
      check("R1 bit_clk", bit_clk, 1'b0, -1);
      check("R1 frame_out", frame_out, 1'b0, -1);
      check("R1 out_valid", out_valid, 1'b0, -1);
    end
    rst_n = 1'b1;

    last_load = -1;
    prev_load = -100;
    ldat = '0;
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      // Inputs for cycle c; noise on non-strobe cycles exercises R7.
      frame_stb = strb[c];
      sample_in = strb[c] ? sdat[c] : W'($urandom);
      if (c >= LAT && strb[c - LAT]) begin
        prev_load = last_load;
        last_load = c;
        ldat = sdat[c - LAT];
      end
      if (last_load < 0) begin
        check("R4 bit_clk idle", bit_clk, 1'b0, c);
        check("R5 frame_out idle", frame_out, 1'b0, c);
        check("R6 out_valid before first", out_valid, 1'b0, c);
        check("R8 ser_data idle", ser_data, 1'b0, c);
      end else begin
        int t;
        t = c - last_load;
        check("R4 bit_clk phase", bit_clk, exp_bitclk(t), c);
        check("R5 frame_out phase", frame_out, exp_marker(t), c);
        if (t < W) begin
          if (t == 0) begin
            check("R2 first bit at latency", ser_data, ldat[0], c);
            if (last_load - prev_load == W)
              check("R9 gapless frame valid", out_valid, 1'b1, c);
          end
          check("R3/R7 data bit", ser_data, ldat[t], c);
          check("R6 out_valid in frame", out_valid, 1'b1, c);
        end else begin
          check("R8 ser_data after frame", ser_data, 1'b0, c);
          check("R8 out_valid after frame", out_valid, 1'b0, c);
        end
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule